// File: doc/BRIEF.md
# Transmit Buffer Priority Selector

This block decides which of a small set of pending transmit buffers is handed to the bus controller next. Each buffer owns an 8-bit local priority register. On every clock the selector looks at all buffers that currently hold a message, which means their empty flag is clear. It picks the one with the numerically smallest priority and registers its index together with a valid flag. When two or more pending buffers share that smallest value, the buffer with the lower index wins.

Software reaches the priority registers through a buffer-select vector, a write strobe with write data, and a read data output. Access is gated. A write lands only in the buffer that the select vector designates, and only while that buffer is empty. A read returns that buffer's value under the same condition and returns zero in every other case. This stops software from changing the priority of a message that is already queued.

Top module: `tx_prio_select`

## Requirements
- R1: While `rst` is high at a rising clock edge, every priority register is cleared to 0 and `win_valid` and `win_idx` are cleared to 0.
- R2: `win_valid` is high exactly when at least one bit of `buf_empty` was 0 at the previous rising edge. A 0 in `buf_empty[i]` means buffer i is pending. The outputs lag their inputs by one clock.
- R3: When `win_valid` is high, `win_idx` holds the index of a buffer that was pending at the previous edge, and no other pending buffer had a smaller priority value.
- R4: When several pending buffers share the smallest priority value, `win_idx` holds the lowest index among them.
- R5: A write (`cpu_wr` high at a rising edge) stores `cpu_wdata` into the effective selected buffer only if that buffer's `buf_empty` bit is 1. In every other case no priority register changes.
- R6: `cpu_rdata` is combinational. It equals the priority of the effective selected buffer when that buffer's `buf_empty` bit is 1, and is 0 otherwise.
- R7: The effective selected buffer is the one given by the lowest set bit of `cpu_sel`, where bit i stands for buffer i. When `cpu_sel` is all zero, no buffer is selected: writes are ignored and reads return 0.
- R8: When `win_valid` is low, `win_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| buf_empty | input | NUM_BUF | Per-buffer empty flag; 0 marks a pending buffer |
| cpu_sel | input | NUM_BUF | Buffer select vector for register access; the lowest set bit counts |
| cpu_wr | input | 1 | Write strobe for the selected priority register |
| cpu_wdata | input | PRIO_W | Priority value to write |
| cpu_rdata | output | PRIO_W | Priority of the selected buffer when access is open, else 0 |
| win_idx | output | IDX_W | Registered index of the winning pending buffer |
| win_valid | output | 1 | Registered flag: at least one buffer was pending |

## Verification
The assertions assume that `buf_empty`, `cpu_sel`, `cpu_wr` and `cpu_wdata` are settled before each rising edge. They also assume that `rst` is held for at least one edge before any check is meaningful. The valid-flag check therefore waits for one full cycle outside reset before it arms.

The stimulus changes inputs only on falling edges. It writes priorities only while every buffer is flagged empty, and only after that does it mark a random subset as pending, so each winner comparison sees settled registers. Priorities are drawn from a narrow range, with deliberate all-equal rounds, so that ties are frequent.

// File: rtl/tps_pkg.sv
package tps_pkg;
  // Index width that stays at least one bit wide.
  function automatic int idx_width(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/tps_access.sv
module tps_access #(
  parameter int NUM_BUF = 3,
  parameter int PRIO_W  = 8,
  parameter int IDX_W   = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_BUF-1:0]             cpu_sel,
  input  logic                           cpu_wr,
  input  logic [NUM_BUF-1:0]             buf_empty,
  input  logic [NUM_BUF-1:0][PRIO_W-1:0] prio_q,
  output logic [NUM_BUF-1:0]             wr_en,
  output logic [PRIO_W-1:0]              cpu_rdata
);
  logic             sel_hit;
  logic [IDX_W-1:0] sel_idx;
  logic             acc_open;

  // Lowest set select bit wins: scan downward so the last hit is the lowest.
  always_comb begin
    sel_hit = 1'b0;
    sel_idx = '0;
    for (int i = NUM_BUF - 1; i >= 0; i--) begin
      if (cpu_sel[i]) begin
        sel_hit = 1'b1;
        sel_idx = IDX_W'(i);
      end
    end
  end

  assign acc_open  = sel_hit && buf_empty[sel_idx];
  assign wr_en     = (acc_open && cpu_wr) ? (NUM_BUF'(1) << sel_idx) : '0;
  assign cpu_rdata = acc_open ? prio_q[sel_idx] : '0;

  // R7: with nothing selected the read port is quiet
  a_r7_no_sel_read_zero: assert property (@(posedge clk) disable iff (rst)
    (cpu_sel == '0) |-> (cpu_rdata == '0));
  // R6: a pending selected buffer never exposes data
  a_r6_pending_read_zero: assert property (@(posedge clk) disable iff (rst)
    (cpu_sel[0] && !buf_empty[0]) |-> (cpu_rdata == '0));
endmodule

// File: rtl/tps_prio_regs.sv
module tps_prio_regs #(
  parameter int NUM_BUF = 3,
  parameter int PRIO_W  = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_BUF-1:0]             wr_en,
  input  logic [PRIO_W-1:0]              wr_data,
  output logic [NUM_BUF-1:0][PRIO_W-1:0] prio_q
);
  for (genvar g = 0; g < NUM_BUF; g++) begin : g_buf
    always_ff @(posedge clk) begin
      if (rst)           prio_q[g] <= '0;
      else if (wr_en[g]) prio_q[g] <= wr_data;
    end

    // R5: a register without an enable keeps its value
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
      !wr_en[g] |=> $stable(prio_q[g]));
  end
endmodule

// File: rtl/tps_pick.sv
module tps_pick #(
  parameter int NUM_BUF = 3,
  parameter int PRIO_W  = 8,
  parameter int IDX_W   = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_BUF-1:0]             buf_empty,
  input  logic [NUM_BUF-1:0][PRIO_W-1:0] prio_q,
  output logic [IDX_W-1:0]               win_idx,
  output logic                           win_valid
);
  logic              best_v;
  logic [IDX_W-1:0]  best_i;
  logic [PRIO_W-1:0] best_p;

  // Ascending scan with strict less-than keeps the lower index on ties.
  always_comb begin
    best_v = 1'b0;
    best_i = '0;
    best_p = '0;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (!buf_empty[i] && (!best_v || prio_q[i] < best_p)) begin
        best_v = 1'b1;
        best_i = IDX_W'(i);
        best_p = prio_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_valid <= 1'b0;
      win_idx   <= '0;
    end else begin
      win_valid <= best_v;
      win_idx   <= best_v ? best_i : '0;
    end
  end

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_chk
    // R3: the chosen buffer is pending and not beaten by any pending buffer
    a_r3_no_smaller: assert property (@(posedge clk) disable iff (rst)
      (best_v && !buf_empty[g]) |-> (prio_q[best_i] <= prio_q[g]));
    a_r3_pick_pending: assert property (@(posedge clk) disable iff (rst)
      (best_v && best_i == IDX_W'(g)) |-> !buf_empty[g]);
    // R4: a pending lower index with an equal value would have won
    a_r4_tie_low: assert property (@(posedge clk) disable iff (rst)
      (best_v && !buf_empty[g] && IDX_W'(g) < best_i) |-> (prio_q[g] > prio_q[best_i]));
  end
endmodule

// File: rtl/tx_prio_select.sv
module tx_prio_select #(
  parameter int NUM_BUF = 3,
  parameter int PRIO_W  = 8,
  localparam int IDX_W  = tps_pkg::idx_width(NUM_BUF)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_BUF-1:0] buf_empty,
  input  logic [NUM_BUF-1:0] cpu_sel,
  input  logic               cpu_wr,
  input  logic [PRIO_W-1:0]  cpu_wdata,
  output logic [PRIO_W-1:0]  cpu_rdata,
  output logic [IDX_W-1:0]   win_idx,
  output logic               win_valid
);
  logic [NUM_BUF-1:0][PRIO_W-1:0] prio_q;
  logic [NUM_BUF-1:0]             wr_en;
  logic                           armed;

  tps_access #(.NUM_BUF(NUM_BUF), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_access (
    .clk(clk), .rst(rst), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
    .buf_empty(buf_empty), .prio_q(prio_q), .wr_en(wr_en), .cpu_rdata(cpu_rdata)
  );

  tps_prio_regs #(.NUM_BUF(NUM_BUF), .PRIO_W(PRIO_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(cpu_wdata), .prio_q(prio_q)
  );

  tps_pick #(.NUM_BUF(NUM_BUF), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_pick (
    .clk(clk), .rst(rst), .buf_empty(buf_empty), .prio_q(prio_q),
    .win_idx(win_idx), .win_valid(win_valid)
  );

  // Marks that the previous edge was outside reset, for one-cycle lookback.
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R2: valid follows the pending set with one clock of latency
  a_r2_valid_lag: assert property (@(posedge clk) disable iff (rst || !armed)
    win_valid == $past(buf_empty != '1));
  // R8: idle index is zero
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !win_valid |-> (win_idx == '0));

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_wchk
    // R5: a register enable needs the strobe, the select bit and an empty buffer
    a_r5_write_gate: assert property (@(posedge clk) disable iff (rst)
      wr_en[g] |-> (cpu_wr && cpu_sel[g] && buf_empty[g]));
    // R7: a lower select bit masks every higher one
    if (g > 0) begin : g_mask
      a_r7_low_masks: assert property (@(posedge clk) disable iff (rst)
        (cpu_sel[0]) |-> !wr_en[g]);
    end
  end
endmodule

// File: tb/sim_tx_prio_select.sv
module sim_tx_prio_select;
  localparam int NB = 3;
  localparam int PW = 8;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NB-1:0] buf_empty = '1;
  logic [NB-1:0] cpu_sel = '0;
  logic          cpu_wr = 1'b0;
  logic [PW-1:0] cpu_wdata = '0;
  logic [PW-1:0] cpu_rdata;
  logic [IW-1:0] win_idx;
  logic          win_valid;

  always #5 clk = ~clk;

  tx_prio_select #(.NUM_BUF(NB), .PRIO_W(PW)) u0 (
    .clk(clk), .rst(rst), .buf_empty(buf_empty), .cpu_sel(cpu_sel),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .win_idx(win_idx), .win_valid(win_valid)
  );

  int            n_chk = 0;
  int            n_fail = 0;
  logic [PW-1:0] model [NB];
  logic [IW:0]   exp_q [$];
  string         tag_q [$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected winner from the rules: smallest value, then smallest index.
  function automatic logic [IW:0] ref_pick(input logic [NB-1:0] e);
    logic          v = 1'b0;
    logic [IW-1:0] ix = '0;
    for (int i = 0; i < NB; i++)
      if (!e[i] && (!v || model[i] < model[ix])) begin
        v  = 1'b1;
        ix = IW'(i);
      end
    return {v, ix};
  endfunction

  function automatic int eff_sel(input logic [NB-1:0] s);
    for (int i = 0; i < NB; i++) if (s[i]) return i;
    return -1;
  endfunction

  // Driver: new empty pattern, expectation queued after the capturing edge.
  task automatic drive_empty(input logic [NB-1:0] e, input string tag);
    @(negedge clk);
    buf_empty = e;
    @(posedge clk);
    #1;
    exp_q.push_back(ref_pick(e));
    tag_q.push_back(tag);
  endtask

  task automatic wr(input logic [NB-1:0] s, input logic [PW-1:0] d);
    int k;
    @(negedge clk);
    cpu_sel = s; cpu_wr = 1'b1; cpu_wdata = d;
    @(posedge clk);
    #1;
    cpu_wr = 1'b0;
    k = eff_sel(s);
    if (k >= 0 && buf_empty[k]) model[k] = d;
  endtask

  task automatic rd_chk(input logic [NB-1:0] s, input string tag);
    int k;
    logic [PW-1:0] e;
    @(negedge clk);
    cpu_sel = s;
    #1;
    k = eff_sel(s);
    e = (k >= 0 && buf_empty[k]) ? model[k] : '0;
    chk({tag, " rdata"}, 32'(cpu_rdata), 32'(e));
  endtask

  // Monitor: pops one expectation per falling edge.
  always @(negedge clk) begin
    logic [IW:0] e;
    string t;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk({t, " valid"}, 32'(win_valid), 32'(e[IW]));
      chk({t, " idx"}, 32'(win_idx), 32'(e[IW-1:0]));
    end
  end

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [PW-1:0] v;
    for (int i = 0; i < NB; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 valid", 32'(win_valid), 0);
    chk("R1 idx", 32'(win_idx), 0);
    for (int i = 0; i < NB; i++) rd_chk(NB'(1) << i, "R1");

    // R5 / R6: gated write and read
    wr(3'b010, 8'h5A);
    rd_chk(3'b010, "R5");
    drive_empty(3'b101, "R2");
    wr(3'b010, 8'h33);
    rd_chk(3'b010, "R6");
    drive_empty(3'b111, "R8");
    rd_chk(3'b010, "R5 ignored");

    // R7: lowest select bit decides
    wr(3'b110, 8'h11);
    rd_chk(3'b010, "R7");
    drive_empty(3'b110, "R2");
    wr(3'b011, 8'h77);
    rd_chk(3'b011, "R7 masked");
    drive_empty(3'b111, "R8");
    rd_chk(3'b010, "R7 kept");
    rd_chk(3'b001, "R7 kept");
    wr(3'b000, 8'h99);
    rd_chk(3'b000, "R7 none");
    for (int i = 0; i < NB; i++) rd_chk(NB'(1) << i, "R7 none");

    // R4: explicit all-equal cases
    for (int i = 0; i < NB; i++) wr(NB'(1) << i, 8'h40);
    drive_empty(3'b000, "R4");
    drive_empty(3'b001, "R4");
    drive_empty(3'b011, "R4");
    drive_empty(3'b111, "R8");

    // R3 / R4: random priorities with frequent ties
    for (int k = 0; k < 60; k++) begin
      drive_empty(3'b111, "R8");
      v = PW'($urandom_range(0, 3));
      for (int b = 0; b < NB; b++)
        wr(NB'(1) << b, (k % 5 == 0) ? v :
           (($urandom_range(0, 7) == 0) ? 8'hFF : PW'($urandom_range(0, 3))));
      drive_empty(NB'($urandom_range(0, 7)), "R3/R4");
      drive_empty(NB'($urandom_range(0, 6)), "R2 R3");
    end

    drive_empty(3'b111, "R8");
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule